// File: doc/BRIEF.md
# Double-Buffered Serial Character Transmitter

This block turns parallel characters into an asynchronous serial stream on one line. It runs from a clock at sixteen times the bit rate. A holding buffer sits in front of the shift register, so a host can hand over the next character while the current one is still going out. That character then follows the previous one with no idle time between them.

Each character is framed as follows. A low start bit comes first. The data bits follow, least significant first. An optional parity bit comes next, then one or more high stop bits. A format word, taken at the moment a character moves from the holding buffer into the shift register, sets four things: the character length (5 to 8 bits), whether parity is sent, whether parity is even or odd, and whether a long stop period is used. The long stop period is one and a half bits for 5-bit characters and two bits for every other length.

Two flags support the handshake. `hold_empty` says the buffer can take a new character. `shift_empty` says the line has finished its last stop bit. After reset the block waits a fixed settling time before it will start a character.

Top module: `uart_tx_dbuf`

## Requirements
- R1: `len_sel` sets the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bit 0 goes out first. Input bits at or above the selected length are ignored.
- R2: With `par_off` low, one parity bit follows the last data bit. With `par_even` high the parity is even over the sent data bits, and with `par_even` low it is odd. With `par_off` high, no parity bit is sent.
- R3: With `stop_long` low the stop period is 16 clocks. With `stop_long` high it is 24 clocks when `len_sel` is 0 and 32 clocks otherwise. The line is high for the whole stop period.
- R4: A frame begins with a low start bit. Each start, data and parity bit holds for exactly 16 clocks.
- R5: `din` is captured on every clock edge at which `load_n` is low, so the last value seen while the strobe is low is the one sent. On the first clock edge that sees `load_n` high after it was low, `hold_empty` goes low.
- R6: If the shifter is idle, the next clock edge after `hold_empty` falls moves the character into the shifter. From that edge on, `hold_empty` is high, `shift_empty` is low and `txd` drives the start bit.
- R7: A character loaded while the shifter is busy stays in the buffer, with `hold_empty` low, until the current stop period ends. Its start bit then follows the last stop clock directly, with zero idle clocks.
- R8: `shift_empty` stays low from the start bit through the last stop clock. It rises on the next clock only when no character is waiting. While it is high, `txd` is high.
- R9: Reset sets `txd`, `hold_empty` and `shift_empty` high. No character starts during the first 18 clocks after reset is released.
- R10: The format inputs are used only at the moment of transfer. Changing them while a character is being sent does not change that character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, 16 times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Parallel character, bit 0 sent first |
| load_n | input | 1 | Active-low buffer load strobe; its rising edge marks the buffer full |
| len_sel | input | 2 | Character length select (5 + value bits) |
| par_off | input | 1 | High disables parity generation |
| par_even | input | 1 | High selects even parity, low selects odd |
| stop_long | input | 1 | High selects 1.5 stop bits (5-bit) or 2 stop bits (others) |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | High when the holding buffer can accept a character |
| shift_empty | output | 1 | High when no character is being sent |

## Verification
The assertions rely on the host pulsing `load_n` only while `hold_empty` is high, so a waiting character is never overwritten. They also rely on the format inputs staying steady from a load until that character is transferred. The driver task keeps to both rules: it waits for `hold_empty` before every load, and it changes the format only at the start of the next load. That still lets the format change while an earlier character is on the line. The monitor compares every line clock of every frame against a waveform it builds from the queued character and format, and it records the idle gap before each start bit.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // Character format, sampled when a character enters the shifter.
  typedef struct packed {
    logic [1:0] len_sel;   // data length = MIN_LEN + len_sel
    logic       par_off;   // no parity bit when set
    logic       par_even;  // even parity when set, odd otherwise
    logic       stop_long; // 1.5 stop bits for shortest length, 2 otherwise
  } txfmt_t;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_n,
  input  logic [DATA_W-1:0] din,
  input  logic              take,
  output logic [DATA_W-1:0] data_q,
  output logic              empty_q
);

  logic load_d;
  logic rise;

  assign rise = load_n & ~load_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_d  <= 1'b1;
      empty_q <= 1'b1;
      data_q  <= '0;
    end else begin
      load_d <= load_n;
      if (!load_n) data_q <= din;
      if (rise)      empty_q <= 1'b0;
      else if (take) empty_q <= 1'b1;
    end
  end

  // R5: release of the strobe marks the buffer full on the next cycle
  p_rise_fills_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(load_n) |=> !empty_q);

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  parameter int OVS     = 16,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(OVS * FRAME_W)
) (
  input  logic [DATA_W-1:0]  data,
  input  txfmt_t             fmt,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   last_tick
);

  int                len;
  int                nbits;
  int                stop_ticks;
  logic [DATA_W-1:0] dmask;
  logic              par;

  always_comb begin
    len = MIN_LEN + int'(fmt.len_sel);
    for (int i = 0; i < DATA_W; i++) dmask[i] = data[i] && (i < len);
    par = (^dmask) ^ ~fmt.par_even;

    frame    = '1;
    frame[0] = 1'b0;
    for (int j = 0; j < DATA_W; j++)
      if (j < len) frame[j+1] = dmask[j];
    for (int j = MIN_LEN; j <= DATA_W; j++)
      if (j == len && !fmt.par_off) frame[j+1] = par;

    nbits = 1 + len + (fmt.par_off ? 0 : 1);
    if (!fmt.stop_long)          stop_ticks = OVS;
    else if (fmt.len_sel == 2'd0) stop_ticks = OVS + OVS / 2;
    else                          stop_ticks = 2 * OVS;
    last_tick = CNT_W'(nbits * OVS + stop_ticks - 1);
  end

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = 8,
  parameter int OVS     = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   last_in,
  output logic               txd,
  output logic               busy,
  output logic               at_end
);

  localparam int SH    = $clog2(OVS);
  localparam int IDX_W = CNT_W - SH;
  localparam int SLOTS = 1 << IDX_W;

  logic [SLOTS-1:0] frame_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_q;
  logic [CNT_W-1:0] cnt_nx;
  logic [IDX_W-1:0] idx_nx;

  assign at_end = busy && (cnt == last_q);
  assign cnt_nx = cnt + 1'b1;
  assign idx_nx = cnt_nx[CNT_W-1:SH];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      txd     <= 1'b1;
      cnt     <= '0;
      last_q  <= '0;
      frame_q <= '1;
    end else if (start) begin
      busy    <= 1'b1;
      cnt     <= '0;
      last_q  <= last_in;
      frame_q <= {{(SLOTS-FRAME_W){1'b1}}, frame_in};
      txd     <= frame_in[0];
    end else if (busy) begin
      if (at_end) begin
        busy <= 1'b0;
        txd  <= 1'b1;
      end else begin
        cnt <= cnt_nx;
        txd <= frame_q[idx_nx];
      end
    end
  end

  // R4: every frame opens with a low start bit
  p_start_low_r4: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && !txd));
  // R8: line idles high whenever no character is in flight
  p_idle_high_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  // R3: the tick counter never runs past the programmed frame end
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= last_q));

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OVS     = 16,
  parameter int SETTLE  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic              load_n,
  input  logic [1:0]        len_sel,
  input  logic              par_off,
  input  logic              par_even,
  input  logic              stop_long,
  output logic              txd,
  output logic              hold_empty,
  output logic              shift_empty
);

  localparam int MIN_LEN = DATA_W - 3;
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(OVS * FRAME_W);
  localparam int SW      = $clog2(SETTLE + 1);

  logic [SW-1:0]      scnt;
  logic               ready;
  logic               take;
  logic               busy;
  logic               at_end;
  logic [DATA_W-1:0]  hold_data;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   last_tick;
  txfmt_t             fmt;

  always_ff @(posedge clk) begin
    if (rst)                    scnt <= '0;
    else if (scnt != SW'(SETTLE)) scnt <= scnt + 1'b1;
  end
  assign ready = (scnt == SW'(SETTLE));

  assign fmt  = '{len_sel: len_sel, par_off: par_off, par_even: par_even, stop_long: stop_long};
  assign take = !hold_empty && ready && (!busy || at_end);

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .load_n  (load_n),
    .din     (din),
    .take    (take),
    .data_q  (hold_data),
    .empty_q (hold_empty)
  );

  uart_tx_framer #(
    .DATA_W (DATA_W), .MIN_LEN(MIN_LEN), .OVS(OVS),
    .FRAME_W(FRAME_W), .CNT_W(CNT_W)
  ) u_framer (
    .data      (hold_data),
    .fmt       (fmt),
    .frame     (frame),
    .last_tick (last_tick)
  );

  uart_tx_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W), .OVS(OVS)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .start    (take),
    .frame_in (frame),
    .last_in  (last_tick),
    .txd      (txd),
    .busy     (busy),
    .at_end   (at_end)
  );

  assign shift_empty = ~busy;

  // R9: nothing starts inside the settling window
  p_settle_r9: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !busy);
  // R6: a transfer always leaves the shifter occupied
  p_take_busy_r6: assert property (@(posedge clk) disable iff (rst)
    take |=> !shift_empty);
  // R6: the buffer only frees up by handing its character to the shifter
  p_empty_order_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_empty) |-> !shift_empty);

endmodule

// File: tb/uart_tx_dbuf_test.sv
module uart_tx_dbuf_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = '0;
  logic       load_n = 1'b1;
  logic [1:0] len_sel = '0;
  logic       par_off = 1'b0;
  logic       par_even = 1'b0;
  logic       stop_long = 1'b0;
  logic       txd, hold_empty, shift_empty;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  bit mon_en   = 0;
  bit in_frame = 0;
  int idle_run = 0;
  int gaps[$];
  logic [12:0] expq[$];  // {stop_long, par_even, par_off, len_sel, data}

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_tx_dbuf uut (
    .clk(clk), .rst(rst), .din(din), .load_n(load_n),
    .len_sel(len_sel), .par_off(par_off), .par_even(par_even),
    .stop_long(stop_long), .txd(txd), .hold_empty(hold_empty),
    .shift_empty(shift_empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic [12:0] it);
    return 5 + int'(it[9:8]);
  endfunction

  function automatic int ticks_of(input logic [12:0] it);
    int l = len_of(it);
    int st = !it[12] ? 16 : (l == 5 ? 24 : 32);
    return 16 * (1 + l + (it[10] ? 0 : 1)) + st;
  endfunction

  function automatic logic bit_at(input logic [12:0] it, input int t);
    int l = len_of(it);
    int k, ones;
    if (t < 16) return 1'b0;
    k = t / 16 - 1;
    if (k < l) return it[k];
    if (k == l && !it[10]) begin
      ones = 0;
      for (int i = 0; i < l; i++) ones += int'(it[i]);
      return it[11] ? logic'(ones % 2) : logic'(1 - ones % 2);
    end
    return 1'b1;
  endfunction

  // Monitor: compares every line clock of each frame to the queued item
  initial begin
    forever begin
      @(negedge clk);
      if (rst || !mon_en) idle_run = 0;
      else if (txd === 1'b0) begin
        logic [12:0] it;
        int total, bad, first_t;
        logic first_got, first_exp;
        in_frame = 1;
        gaps.push_back(idle_run);
        idle_run = 0;
        if (expq.size() == 0) begin
          chk(0, "R4 unexpected start bit", 0, 1);
          in_frame = 0;
        end else begin
          it = expq.pop_front();
          total = ticks_of(it);
          bad = 0; first_t = -1; first_got = 1'b0; first_exp = 1'b0;
          for (int t = 0; t < total; t++) begin
            if (t > 0) @(negedge clk);
            if (txd !== bit_at(it, t) || shift_empty !== 1'b0) begin
              if (bad == 0) begin
                first_t = t; first_got = txd; first_exp = bit_at(it, t);
              end
              bad++;
            end
          end
          if (bad != 0)
            $display("  frame data=%h fmt=%b first bad tick %0d", it[7:0], it[12:8], first_t);
          chk(bad == 0, "R1/R2/R3/R4/R8 frame waveform", int'(first_got), int'(first_exp));
          in_frame = 0;
        end
      end else idle_run++;
    end
  end

  task automatic send(input logic [7:0] d, input logic [1:0] ls, input logic po,
                      input logic pe, input logic sl, input int nlow);
    @(negedge clk);
    while (hold_empty !== 1'b1) @(negedge clk);
    len_sel = ls; par_off = po; par_even = pe; stop_long = sl;
    load_n = 1'b0;
    din = (nlow > 1) ? ~d : d;
    for (int i = 1; i < nlow; i++) begin
      @(negedge clk);
      din = (i == nlow - 1) ? d : ~d;
    end
    @(negedge clk);
    load_n = 1'b1;
    din = 8'h00;
    expq.push_back({sl, pe, po, ls, d});
  endtask

  task automatic drain();
    @(negedge clk);
    while (!(expq.size() == 0 && !in_frame && shift_empty === 1'b1)) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(txd === 1'b1, "R9 txd after reset", int'(txd), 1);
    chk(hold_empty === 1'b1, "R9 hold_empty after reset", int'(hold_empty), 1);
    chk(shift_empty === 1'b1, "R9 shift_empty after reset", int'(shift_empty), 1);

    // R9: a character loaded right away waits out the settling window
    rst = 1'b0;
    mon_en = 1;
    fork
      send(8'h3C, 2'd3, 1'b1, 1'b0, 1'b0, 1);
      begin
        int quiet = 0;
        for (int i = 0; i < 17; i++) begin
          @(negedge clk);
          if (txd === 1'b1 && shift_empty === 1'b1) quiet++;
        end
        chk(quiet == 17, "R9 line quiet during settle", quiet, 17);
      end
    join
    drain();

    // R5/R6: handshake timing with an idle shifter
    send(8'h96, 2'd3, 1'b0, 1'b1, 1'b0, 1);
    @(negedge clk);
    chk(hold_empty === 1'b0, "R5 hold_empty falls after strobe rise", int'(hold_empty), 0);
    chk(shift_empty === 1'b1, "R6 shifter still idle before transfer", int'(shift_empty), 1);
    @(negedge clk);
    chk(hold_empty === 1'b1, "R6 hold_empty back high at transfer", int'(hold_empty), 1);
    chk(shift_empty === 1'b0, "R6 shift_empty low at transfer", int'(shift_empty), 0);
    chk(txd === 1'b0, "R6 start bit at transfer", int'(txd), 0);
    drain();
    @(negedge clk);
    chk(shift_empty === 1'b1 && txd === 1'b1, "R8 idle after last stop",
        int'({shift_empty, txd}), 3);

    // R5: long strobe, only the last captured value is sent
    send(8'h5A, 2'd2, 1'b0, 1'b0, 1'b1, 4);
    drain();

    // R1/R2/R3: every length, parity mode and stop selection; high bits set
    for (int ls = 0; ls < 4; ls++)
      for (int pm = 0; pm < 3; pm++)
        for (int sl = 0; sl < 2; sl++) begin
          logic [7:0] d = 8'hE5 ^ 8'(ls * 37 + pm * 11 + sl * 90);
          send(d, 2'(ls), pm == 0, pm == 1, 1'(sl), 1 + (ls + pm) % 3);
          drain();
        end

    // R7/R10: chained characters with the format changing in flight
    gaps.delete();
    send(8'hC3, 2'd3, 1'b0, 1'b1, 1'b1, 1);
    send(8'hF1, 2'd0, 1'b0, 1'b0, 1'b1, 2);
    @(negedge clk);
    chk(hold_empty === 1'b0, "R7 second character waits in buffer", int'(hold_empty), 0);
    repeat (40) @(negedge clk);
    chk(hold_empty === 1'b0, "R7 still waiting while first is sent", int'(hold_empty), 0);
    chk(shift_empty === 1'b0, "R8 busy mid-character", int'(shift_empty), 0);
    send(8'h6E, 2'd2, 1'b1, 1'b0, 1'b0, 1);
    drain();
    chk(gaps.size() == 3, "R7 three chained frames seen", gaps.size(), 3);
    if (gaps.size() == 3) begin
      chk(gaps[1] == 0, "R7 no gap before second character", gaps[1], 0);
      chk(gaps[2] == 0, "R7 no gap before third character", gaps[2], 0);
    end
    chk(expq.size() == 0, "R10 all queued characters sent", expq.size(), 0);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule